// File: doc/BRIEF.md
# I2C Target Address-Match Receiver

This block is the receive half of an I2C target. It watches the synchronized SCL and SDA lines and finds START and STOP conditions. It shifts in each byte on the rising edges of SCL and compares the first byte of a transfer with an address register that software writes. When the address matches, the block pulls SDA low for the acknowledge bit. It copies each accepted byte into a receive buffer and raises an interrupt flag.

Two address widths are supported. A 7-bit address is checked in a single byte. A 10-bit address takes two bytes and a handshake with software. After each address byte, the block holds SCL low and sets an update flag. Software then rewrites the compare register, which clears the flag and releases the clock. A receive buffer that is still full, or an overflow that software has not yet cleared, stops the acknowledge. The block drives no line high. Its only outputs to the bus are pull-down enables for open-drain pads.

Top module: `i2c_addr_rx`

## Requirements
- R1: After reset, `buf_full`, `ovf`, `irq`, `upd_addr`, `scl_pd` and `sda_pd` are all 0. While `en` is 0, both pull-downs are released from the next clock onward.
- R2: Bytes are shifted MSB first on SCL rising edges only after a START (SDA falling while SCL is high). Clock pulses that come before any START are not acknowledged and load nothing.
- R3: In 7-bit mode (`mode_10b`=0), the address byte matches when its bits 7:1 equal `addr_wdata` bits 7:1 as last written, and bit 0 is the read/write bit. On a match, with `buf_full` and `ovf` both clear, `sda_pd` is held from the falling edge of the 8th SCL pulse to the falling edge of the 9th. The whole byte is loaded into `rx_data` and `buf_full` is set. `irq` is set after the 9th falling edge.
- R4: A non-matching address is not acknowledged and changes no flag. The bytes that follow it in the same transfer are ignored until the next START.
- R5: If `buf_full` or `ovf` is already set when a byte for this target completes, the byte is not acknowledged and `rx_data` keeps its old value, but `irq` is still set. If `buf_full` was set, `ovf` is set.
- R6: A `buf_rd` pulse clears `buf_full`, an `ovf_clr` pulse clears `ovf`, and an `irq_clr` pulse clears `irq`. `ovf` is cleared by nothing other than `ovf_clr`.
- R7: After a write-address match, every later data byte of the transfer that arrives while the buffer is free is acknowledged and loaded.
- R8: In 10-bit mode, the first byte must be 11110 followed by A9, A8 and a read/write bit of 0, and its bits 7:1 must equal address register bits 7:1. On a match, `upd_addr` is set and SCL is held low from the 9th falling edge. A write to the address register clears `upd_addr` and releases SCL at the next clock.
- R9: In 10-bit mode, the second byte is compared with all 8 bits of the address register. On a match it is acknowledged and loaded, and the same `upd_addr` and SCL-hold handshake follows.
- R10: After a full 10-bit match, a repeated START followed by the high address byte with read/write = 1 is acknowledged, loaded and flagged in `irq`, without an `upd_addr` handshake or clock stretch.
- R11: With `se_irq_en`=1, each START and each STOP sets `irq`. With `se_irq_en`=0 they do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enables the receiver |
| mode_10b | input | 1 | Selects 10-bit addressing |
| se_irq_en | input | 1 | Raises irq on START and STOP |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_pd | output | 1 | Pull-down enable for SCL (clock stretch) |
| sda_pd | output | 1 | Pull-down enable for SDA (acknowledge) |
| addr_wr | input | 1 | Write strobe for the address register |
| addr_wdata | input | 8 | Address register write data |
| buf_rd | input | 1 | Read strobe for the receive buffer |
| ovf_clr | input | 1 | Clears the overflow flag |
| irq_clr | input | 1 | Clears the interrupt flag |
| rx_data | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| ovf | output | 1 | A byte arrived while the buffer was full |
| irq | output | 1 | Interrupt flag |
| upd_addr | output | 1 | Software must rewrite the address register |

## Verification
The bench checks three cases where the acknowledge is refused:
- a full buffer, which also sets the overflow flag;
- a pending overflow after the buffer has been read, where a design that only looked at the full flag would acknowledge and overwrite data;
- an address that does not match, where a design that kept shifting would acknowledge later data bytes.

It runs the complete 10-bit handshake. It checks that SCL stays low until the address register is written. A design that forgot to release SCL would hang the bus master. One that set the update flag after the repeated-START read byte would stall a read that should go straight on. Clock pulses before any START, and the START and STOP interrupts, are also checked. These catch designs that shift without framing, or that ignore the interrupt-enable setting.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RX   = 2'd1,
        ST_SKIP = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        K_ADDR    = 2'd0,
        K_ADDR_LO = 2'd1,
        K_DATA    = 2'd2,
        K_SKIP    = 2'd3
    } byte_kind_e;

    localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_q;
    logic              scl_prev_q;
    logic              sda_prev_q;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_in};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_in};
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    // SDA moving while SCL is high marks a bus condition.
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2c_rx_core.sv
module i2c_rx_core
    import i2c_rx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          mode_10b,
    input  logic          se_irq_en,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          addr_wr,
    input  logic [DW-1:0] addr_wdata,
    input  logic          buf_rd,
    input  logic          ovf_clr,
    input  logic          irq_clr,
    output logic          sda_pd,
    output logic          scl_pd,
    output logic [DW-1:0] rx_data,
    output logic          buf_full,
    output logic          ovf,
    output logic          irq,
    output logic          upd_addr
);
    localparam int            CW       = $clog2(DW + 2);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW);
    localparam logic [CW-1:0] ACK_END  = CW'(DW + 1);

    typedef struct packed {
        rx_state_e   st;
        byte_kind_e  kind;
        byte_kind_e  nxt;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sr;
        logic [DW-1:0] rbuf;
        logic [DW-1:0] addr;
        logic        bf;
        logic        ovf;
        logic        irq;
        logic        upd;
        logic        hold;
        logic        ack;
        logic        pend;
        logic        pend_upd;
        logic        ten;
    } core_t;

    core_t      s_d, s_q;
    logic       hit;
    logic       need_upd;
    logic       blocked;
    byte_kind_e nxt_kind;

    always_comb begin
        s_d      = s_q;
        hit      = 1'b0;
        need_upd = 1'b0;
        nxt_kind = K_DATA;
        blocked  = s_q.bf | s_q.ovf;

        if (buf_rd)  s_d.bf  = 1'b0;
        if (ovf_clr) s_d.ovf = 1'b0;
        if (irq_clr) s_d.irq = 1'b0;

        if (!en) begin
            s_d.st       = ST_IDLE;
            s_d.cnt      = '0;
            s_d.ack      = 1'b0;
            s_d.hold     = 1'b0;
            s_d.pend     = 1'b0;
            s_d.pend_upd = 1'b0;
            s_d.ten      = 1'b0;
        end else if (start_det) begin
            s_d.st       = ST_RX;
            s_d.kind     = K_ADDR;
            s_d.cnt      = '0;
            s_d.ack      = 1'b0;
            s_d.hold     = 1'b0;
            s_d.pend     = 1'b0;
            s_d.pend_upd = 1'b0;
            if (se_irq_en) s_d.irq = 1'b1;
        end else if (stop_det) begin
            s_d.st       = ST_IDLE;
            s_d.ack      = 1'b0;
            s_d.hold     = 1'b0;
            s_d.pend     = 1'b0;
            s_d.pend_upd = 1'b0;
            s_d.ten      = 1'b0;
            if (se_irq_en) s_d.irq = 1'b1;
        end else if (s_q.st == ST_RX) begin
            if (scl_rise && s_q.cnt != ACK_END) begin
                if (s_q.cnt < LAST_BIT) s_d.sr = {s_q.sr[DW-2:0], sda_s};
                s_d.cnt = s_q.cnt + 1'b1;
            end
            // Decision point: falling edge of the last data pulse.
            if (scl_fall && s_q.cnt == LAST_BIT) begin
                unique case (s_q.kind)
                    K_ADDR: begin
                        if (mode_10b) begin
                            if (s_q.sr[DW-1 -: 5] == TEN_BIT_PREFIX &&
                                s_q.sr[DW-1:1] == s_q.addr[DW-1:1]) begin
                                if (!s_q.sr[0]) begin
                                    hit      = 1'b1;
                                    need_upd = 1'b1;
                                    nxt_kind = K_ADDR_LO;
                                end else if (s_q.ten) begin
                                    hit      = 1'b1;
                                    nxt_kind = K_SKIP;
                                end
                            end
                        end else if (s_q.sr[DW-1:1] == s_q.addr[DW-1:1]) begin
                            hit      = 1'b1;
                            nxt_kind = s_q.sr[0] ? K_SKIP : K_DATA;
                        end
                    end
                    K_ADDR_LO: begin
                        if (s_q.sr == s_q.addr) begin
                            hit      = 1'b1;
                            need_upd = 1'b1;
                            nxt_kind = K_DATA;
                        end
                    end
                    K_DATA: begin
                        hit      = 1'b1;
                        nxt_kind = K_DATA;
                    end
                    default: hit = 1'b0;
                endcase

                if (!hit) begin
                    s_d.st = ST_SKIP;
                end else begin
                    s_d.pend = 1'b1;
                    if (s_q.bf) s_d.ovf = 1'b1;
                    if (blocked) begin
                        s_d.pend_upd = 1'b0;
                        s_d.nxt      = (s_q.kind == K_DATA) ? K_DATA : K_SKIP;
                    end else begin
                        s_d.rbuf     = s_q.sr;
                        s_d.bf       = 1'b1;
                        s_d.ack      = 1'b1;
                        s_d.pend_upd = need_upd;
                        s_d.nxt      = nxt_kind;
                        if (s_q.kind == K_ADDR_LO) s_d.ten = 1'b1;
                    end
                end
            end
            // End of the acknowledge pulse.
            if (scl_fall && s_q.cnt == ACK_END) begin
                s_d.ack  = 1'b0;
                s_d.cnt  = '0;
                s_d.kind = s_q.nxt;
                if (s_q.pend) s_d.irq = 1'b1;
                if (s_q.pend_upd) begin
                    s_d.upd  = 1'b1;
                    s_d.hold = 1'b1;
                end
                s_d.pend     = 1'b0;
                s_d.pend_upd = 1'b0;
                if (s_q.nxt == K_SKIP) s_d.st = ST_SKIP;
            end
        end

        if (addr_wr) begin
            s_d.addr = addr_wdata;
            s_d.upd  = 1'b0;
            s_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sda_pd   = s_q.ack;
    assign scl_pd   = s_q.hold;
    assign rx_data  = s_q.rbuf;
    assign buf_full = s_q.bf;
    assign ovf      = s_q.ovf;
    assign irq      = s_q.irq;
    assign upd_addr = s_q.upd;

endmodule

// File: rtl/i2c_addr_rx.sv
module i2c_addr_rx #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          mode_10b,
    input  logic          se_irq_en,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          scl_pd,
    output logic          sda_pd,
    input  logic          addr_wr,
    input  logic [DW-1:0] addr_wdata,
    input  logic          buf_rd,
    input  logic          ovf_clr,
    input  logic          irq_clr,
    output logic [DW-1:0] rx_data,
    output logic          buf_full,
    output logic          ovf,
    output logic          irq,
    output logic          upd_addr
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rx_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .mode_10b   (mode_10b),
        .se_irq_en  (se_irq_en),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .addr_wr    (addr_wr),
        .addr_wdata (addr_wdata),
        .buf_rd     (buf_rd),
        .ovf_clr    (ovf_clr),
        .irq_clr    (irq_clr),
        .sda_pd     (sda_pd),
        .scl_pd     (scl_pd),
        .rx_data    (rx_data),
        .buf_full   (buf_full),
        .ovf        (ovf),
        .irq        (irq),
        .upd_addr   (upd_addr)
    );

endmodule

// File: rtl/i2c_addr_rx_chk.sv
module i2c_addr_rx_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          addr_wr,
    input logic          ovf_clr,
    input logic          sda_pd,
    input logic          scl_pd,
    input logic [DW-1:0] rx_data,
    input logic          buf_full,
    input logic          ovf,
    input logic          upd_addr
);
    assert_release_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!sda_pd && !scl_pd));

    assert_ack_with_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pd) |-> $rose(buf_full));

    assert_buffer_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> $rose(buf_full));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    assert_addr_write_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr |=> (!upd_addr && !scl_pd));

endmodule

bind i2c_addr_rx i2c_addr_rx_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .addr_wr  (addr_wr),
    .ovf_clr  (ovf_clr),
    .sda_pd   (sda_pd),
    .scl_pd   (scl_pd),
    .rx_data  (rx_data),
    .buf_full (buf_full),
    .ovf      (ovf),
    .upd_addr (upd_addr)
);

// File: tb/sim_i2c_addr_rx.sv
`timescale 1ns/1ps
module sim_i2c_addr_rx;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n, en, mode_10b, se_irq_en;
    logic m_scl, m_sda;
    logic addr_wr, buf_rd, ovf_clr, irq_clr;
    logic [7:0] addr_wdata;
    logic scl_pd, sda_pd, buf_full, ovf, irq, upd_addr;
    logic [7:0] rx_data;
    logic scl_line, sda_line;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        string      req;
        logic [7:0] val;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    assign scl_line = m_scl & ~scl_pd;
    assign sda_line = m_sda & ~sda_pd;

    i2c_addr_rx u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_10b(mode_10b), .se_irq_en(se_irq_en),
        .scl_in(scl_line), .sda_in(sda_line), .scl_pd(scl_pd), .sda_pd(sda_pd),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata), .buf_rd(buf_rd),
        .ovf_clr(ovf_clr), .irq_clr(irq_clr), .rx_data(rx_data),
        .buf_full(buf_full), .ovf(ovf), .irq(irq), .upd_addr(upd_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic waitq(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(ref logic sig);
        @(posedge clk); #1 sig = 1'b1;
        @(posedge clk); #1 sig = 1'b0;
        waitq(2);
    endtask

    task automatic write_addr(input logic [7:0] a);
        @(posedge clk); #1 addr_wdata = a; addr_wr = 1'b1;
        @(posedge clk); #1 addr_wr = 1'b0;
        waitq(2);
    endtask

    task automatic push(input string req, input logic [7:0] v);
        exp_t e;
        e.req = req;
        e.val = v;
        exp_q.push_back(e);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1;
        wait (scl_line === 1'b1);
        waitq(Q);
        m_sda = 1'b0; waitq(Q);
        m_scl = 1'b0; waitq(Q);
    endtask

    task automatic bus_rep_start();
        m_sda = 1'b1; waitq(Q);
        m_scl = 1'b1;
        wait (scl_line === 1'b1);
        waitq(Q);
        m_sda = 1'b0; waitq(Q);
        m_scl = 1'b0; waitq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; waitq(Q);
        m_scl = 1'b1;
        wait (scl_line === 1'b1);
        waitq(Q);
        m_sda = 1'b1; waitq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; waitq(Q);
            m_scl = 1'b1;
            wait (scl_line === 1'b1);
            waitq(2 * Q);
            m_scl = 1'b0; waitq(Q);
        end
        m_sda = 1'b1; waitq(Q);
        m_scl = 1'b1;
        wait (scl_line === 1'b1);
        waitq(Q);
        ack = ~sda_line;
        waitq(Q);
        m_scl = 1'b0; waitq(Q);
    endtask

    // Scoreboard monitor: each new buffer load is compared with the oldest expectation.
    initial begin
        logic prev_bf;
        exp_t e;
        prev_bf = 1'b0;
        forever begin
            @(posedge clk); #2;
            if (rst_n && buf_full && !prev_bf) begin
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected buffer load", int'(rx_data), -1);
                end else begin
                    e = exp_q.pop_front();
                    chk(e.req, int'(rx_data), int'(e.val));
                end
            end
            prev_bf = buf_full;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic ack;
        rst_n = 1'b0; en = 1'b0; mode_10b = 1'b0; se_irq_en = 1'b0;
        m_scl = 1'b1; m_sda = 1'b1;
        addr_wr = 1'b0; buf_rd = 1'b0; ovf_clr = 1'b0; irq_clr = 1'b0; addr_wdata = '0;
        waitq(5);
        rst_n = 1'b1;
        waitq(2);
        chk("R1 reset flags", {buf_full, ovf, irq, upd_addr}, 0);
        chk("R1 reset pull-downs", {scl_pd, sda_pd}, 0);

        en = 1'b1;
        write_addr(8'hB4);

        // R2: clocking a matching byte with no START.
        m_scl = 1'b0; waitq(Q);
        send_byte(8'hB4, ack);
        chk("R2 no ack before START", ack, 0);
        chk("R2 no load before START", buf_full, 0);
        m_scl = 1'b1; waitq(Q);

        // R3 / R7 / R5 / R6: 7-bit write.
        bus_start();
        push("R3 address byte loaded", 8'hB4);
        send_byte(8'hB4, ack);
        chk("R3 address ack", ack, 1);
        chk("R3 irq after address", irq, 1);
        chk("R3 buffer full", buf_full, 1);
        pulse(buf_rd);
        chk("R6 read clears buffer full", buf_full, 0);
        pulse(irq_clr);
        chk("R6 irq clear", irq, 0);
        push("R7 data byte loaded", 8'h3C);
        send_byte(8'h3C, ack);
        chk("R7 data ack", ack, 1);
        pulse(irq_clr);
        send_byte(8'h77, ack);
        chk("R5 nack on full buffer", ack, 0);
        chk("R5 overflow set", ovf, 1);
        chk("R5 irq still set", irq, 1);
        chk("R5 buffer kept", int'(rx_data), 'h3C);
        pulse(buf_rd);
        chk("R6 ovf survives read", ovf, 1);
        send_byte(8'h11, ack);
        chk("R5 nack on pending overflow", ack, 0);
        chk("R5 no load on pending overflow", buf_full, 0);
        pulse(ovf_clr);
        chk("R6 ovf clear", ovf, 0);
        pulse(irq_clr);
        push("R7 data after overflow clear", 8'h22);
        send_byte(8'h22, ack);
        chk("R7 data ack after clear", ack, 1);
        pulse(buf_rd);
        pulse(irq_clr);
        bus_stop();

        // R4: address mismatch.
        bus_start();
        send_byte(8'hB6, ack);
        chk("R4 mismatch nack", ack, 0);
        send_byte(8'h55, ack);
        chk("R4 following byte ignored", ack, 0);
        chk("R4 no flags", {buf_full, irq, ovf}, 0);
        bus_stop();

        // R11: START / STOP interrupts.
        se_irq_en = 1'b1;
        bus_start();
        chk("R11 irq on START", irq, 1);
        pulse(irq_clr);
        bus_stop();
        chk("R11 irq on STOP", irq, 1);
        pulse(irq_clr);
        se_irq_en = 1'b0;
        bus_start();
        bus_stop();
        chk("R11 no irq when disabled", irq, 0);

        // R8 / R9 / R10: 10-bit address 0x2A5.
        mode_10b = 1'b1;
        write_addr(8'hF4);
        bus_start();
        send_byte(8'hF2, ack);
        chk("R8 wrong upper bits nack", ack, 0);
        chk("R8 no update on miss", upd_addr, 0);
        bus_stop();

        bus_start();
        push("R8 high byte loaded", 8'hF4);
        send_byte(8'hF4, ack);
        chk("R8 high byte ack", ack, 1);
        waitq(2 * Q);
        chk("R8 update flag", upd_addr, 1);
        chk("R8 clock held low", scl_line, 0);
        pulse(buf_rd);
        pulse(irq_clr);
        write_addr(8'hA5);
        chk("R8 write releases", {upd_addr, scl_pd}, 0);
        push("R9 low byte loaded", 8'hA5);
        send_byte(8'hA5, ack);
        chk("R9 low byte ack", ack, 1);
        waitq(2 * Q);
        chk("R9 update flag again", upd_addr, 1);
        chk("R9 clock held low", scl_pd, 1);
        pulse(buf_rd);
        pulse(irq_clr);
        write_addr(8'hF4);
        push("R7 10-bit data loaded", 8'h9C);
        send_byte(8'h9C, ack);
        chk("R7 10-bit data ack", ack, 1);
        pulse(buf_rd);
        pulse(irq_clr);
        bus_rep_start();
        push("R10 read high byte loaded", 8'hF5);
        send_byte(8'hF5, ack);
        chk("R10 read high byte ack", ack, 1);
        waitq(2 * Q);
        chk("R10 no update handshake", {upd_addr, scl_pd}, 0);
        chk("R10 irq set", irq, 1);
        pulse(buf_rd);
        pulse(irq_clr);
        bus_stop();

        en = 1'b0;
        waitq(3);
        chk("R1 released when disabled", {scl_pd, sda_pd}, 0);
        chk("R3 all expected loads seen", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule